// File: doc/BRIEF.md
# Streaming Bit-Reversal Reorder Buffer

This block sits in front of a radix-2 decimation-in-time FFT. It takes an unbroken stream of complex samples, one per clock, whose frames of N points arrive in natural index order. It emits every frame with its samples permuted into bit-reversed index order. Storage is split into two banks of N entries. While one bank fills with the incoming frame at natural addresses, the other bank drains the previous frame at bit-reversed addresses. The roles swap at each frame boundary, so the output also runs at one sample per clock without a gap.

The whole stream is opened by a single one-cycle `start` pulse. The sample presented in that same cycle is natural index 0 of the first frame, and a new sample must follow on every clock after it. There is no per-sample handshake. After one frame of latency, `out_valid` rises and stays high. From then on, `out_idx` gives the slot number of the sample currently on the output within its reordered frame. The frame length N is a power-of-two parameter with a default of 512, and each component of a sample is W bits wide with a default of 12.

Top module: `brr_reorder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_idx`, `out_re` and `out_im` are all zero.
- R2: Input samples presented before the `start` pulse are not stored, and `out_valid` stays low during that time.
- R3: The sample presented in the cycle where `start` is high is natural index 0 of frame 0. Each following clock carries the next natural index, and index N-1 is followed by index 0 of the next frame.
- R4: `out_valid` rises on the clock edge that comes exactly N edges after the edge that captured the `start` sample. It then stays high until reset.
- R5: The output in slot j of a frame carries the input sample whose natural index is bitrev(j). Bit b of j moves to bit log2(N)-1-b.
- R6: Frames leave back to back. Frame k fills output cycles N*(k+1) through N*(k+1)+N-1, counted in edges after the `start` edge, with no idle cycle between frames.
- R7: The real and imaginary parts travel at the full W bits each and are never mixed with each other.
- R8: A `start` pulse that arrives while the stream is already running has no effect on the data, the slot numbering or the timing.
- R9: A reset during streaming discards the stream. A later `start` pulse begins again at frame 0 with the full latency of one frame.
- R10: `out_idx` counts 0, 1, …, N-1 in output order, wraps to 0 and continues while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse marking the first sample of the stream |
| in_re | input | W | Real part of the input sample |
| in_im | input | W | Imaginary part of the input sample |
| out_re | output | W | Real part of the reordered sample |
| out_im | output | W | Imaginary part of the reordered sample |
| out_valid | output | 1 | High once the first frame has been stored |
| out_idx | output | log2(N) | Slot number of the output sample within its frame |

## Verification
The stream is driven with three patterns, and each one exposes a different fault.

- **Counting ramp.** A ramp whose value encodes both the frame and the natural index shows whether the permutation and the frame order are correct.
- **Alternating extremes.** Samples that swing between the most positive and most negative W-bit codes, with opposite signs in the two parts, catch truncation and any swap of the real and imaginary parts.
- **Scrambled values.** A multiplicative scramble over frame and index separates the two banks, so reading the wrong bank or a stale frame shows up.

Further runs add junk samples before `start`, a repeated `start` pulse in the middle of the stream, and a reset in the middle of the stream followed by a fresh start. These check that the stream origin and the latency are fixed only by the first pulse after reset.

// File: rtl/brr_pkg.sv
package brr_pkg;

  // Control phases of the reorder buffer
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,  // waiting for the start pulse
    PH_FILL   = 2'd1,  // first frame being written, nothing to read yet
    PH_STREAM = 2'd2   // one bank filling while the other drains
  } brr_phase_t;

endpackage

// File: rtl/brr_bitrev.sv
module brr_bitrev #(
  parameter int AW = 9
) (
  input  logic [AW-1:0] a,
  output logic [AW-1:0] y
);

  // Mirror the bit positions of the address
  for (genvar i = 0; i < AW; i++) begin : g_mirror
    assign y[i] = a[AW-1-i];
  end

endmodule

// File: rtl/brr_ctrl.sv
module brr_ctrl
  import brr_pkg::*;
#(
  parameter int N  = 512,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          wr_en,
  output logic [AW:0]   wr_addr,
  output logic          rd_en,
  output logic [AW:0]   rd_addr,
  output logic [AW-1:0] rd_slot
);

  localparam logic [AW-1:0] LAST = AW'(N - 1);

  brr_phase_t    phase;
  logic [AW-1:0] cnt;
  logic          bank;
  logic          active;
  logic [AW-1:0] cnt_rev;

  assign active = (phase != PH_IDLE) || start;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      bank  <= 1'b0;
    end else if (active) begin
      cnt <= cnt + AW'(1);
      if (cnt == LAST) begin
        bank <= ~bank;
      end
      case (phase)
        PH_IDLE:  phase <= PH_FILL;
        PH_FILL:  if (cnt == LAST) phase <= PH_STREAM;
        default:  phase <= PH_STREAM;
      endcase
    end
  end

  brr_bitrev #(.AW(AW)) u_rev (
    .a (cnt),
    .y (cnt_rev)
  );

  // Write at the natural address into the filling bank,
  // read at the mirrored address from the draining bank.
  assign wr_en   = active;
  assign wr_addr = {bank, cnt};
  assign rd_en   = active && (phase == PH_STREAM);
  assign rd_addr = {~bank, cnt_rev};
  assign rd_slot = cnt;

  // R6
  bank_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cnt == LAST) |=> (bank != $past(bank)));

  // R8
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && start) |=> (cnt == AW'($past(cnt) + 1)));

  // R3
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == LAST) |=> (cnt == '0));

endmodule

// File: rtl/brr_ram.sv
module brr_ram #(
  parameter int DW = 24,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port memory: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end

  // R6
  bank_split_chk: assert property (@(posedge clk) disable iff (rst)
    (we && re) |-> (waddr[AW-1] != raddr[AW-1]));

endmodule

// File: rtl/brr_reorder.sv
module brr_reorder #(
  parameter int N = 512,
  parameter int W = 12,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  in_re,
  input  logic [W-1:0]  in_im,
  output logic [W-1:0]  out_re,
  output logic [W-1:0]  out_im,
  output logic          out_valid,
  output logic [AW-1:0] out_idx
);

  localparam int DW = 2 * W;

  logic          wr_en;
  logic [AW:0]   wr_addr;
  logic          rd_en;
  logic [AW:0]   rd_addr;
  logic [AW-1:0] rd_slot;
  logic [DW-1:0] rd_word;

  brr_ctrl #(.N(N), .AW(AW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_slot (rd_slot)
  );

  brr_ram #(.DW(DW), .AW(AW + 1)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata ({in_re, in_im}),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  // Flag and slot registers line up with the RAM output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
    end else begin
      out_valid <= rd_en;
      if (rd_en) begin
        out_idx <= rd_slot;
      end
    end
  end

  assign out_re = rd_word[DW-1:W];
  assign out_im = rd_word[W-1:0];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_idx == '0));

  // R4
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  // R10
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> (out_idx == AW'($past(out_idx) + 1)));

endmodule

// File: tb/brr_reorder_test.sv
module brr_reorder_test;

  localparam int N  = 8;
  localparam int W  = 12;
  localparam int LG = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  in_re = '0;
  logic [W-1:0]  in_im = '0;
  logic [W-1:0]  out_re;
  logic [W-1:0]  out_im;
  logic          out_valid;
  logic [LG-1:0] out_idx;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  brr_reorder #(.N(N), .W(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_re     (in_re),
    .in_im     (in_im),
    .out_re    (out_re),
    .out_im    (out_im),
    .out_valid (out_valid),
    .out_idx   (out_idx)
  );

  function automatic int brev(int v);
    int r = 0;
    for (int b = 0; b < LG; b++) begin
      if (((v >> b) & 1) != 0) r |= (1 << (LG - 1 - b));
    end
    return r;
  endfunction

  function automatic logic [W-1:0] pat_re(int sel, int f, int n);
    case (sel)
      0:       return W'(n + 16 * f);
      1:       return (n % 2 == 1) ? 12'h800 : (12'h7FF ^ W'(f));
      default: return W'((n * 29 + f * 113 + 7) * 53);
    endcase
  endfunction

  function automatic logic [W-1:0] pat_im(int sel, int f, int n);
    case (sel)
      0:       return W'(12'hA00 + n * 3 + f);
      1:       return (n % 2 == 1) ? (12'h7FF ^ W'(f)) : 12'h800;
      default: return W'((n * 71 + f * 17 + 3) * 97);
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Hold reset, then check the cleared outputs
  task automatic do_reset(string req);
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, req, "valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, req, "valid after reset", int'(out_valid), 0);
    chk(out_idx == '0, req, "idx after reset", int'(out_idx), 0);
    chk(out_re == '0 && out_im == '0, req, "data after reset",
        int'({out_re, out_im}), 0);
  endtask

  // Drive junk, then a stream of nframes frames; check every output cycle.
  // pulse_at >= 0 re-asserts start at that stream cycle.
  task automatic stream(int sel, int nframes, int junk, int pulse_at, string extra);
    for (int c = -junk; c < nframes * N + N + 1; c++) begin
      @(negedge clk);
      if (c - 1 >= N) begin
        int e = c - 1 - N;
        int j = e % N;
        int f = e / N;
        int n = brev(j);
        string rq = (f == 0 && j == 0) ? "R3" : ((f > 0) ? "R6" : "R5");
        chk(out_valid == 1'b1, {"R4", extra}, "valid", int'(out_valid), 1);
        chk(out_idx == LG'(j), {"R10", extra}, "idx", int'(out_idx), j);
        chk(out_re == pat_re(sel, f, n), {rq, extra}, "re",
            int'(out_re), int'(pat_re(sel, f, n)));
        chk(out_im == pat_im(sel, f, n), {"R7", extra}, "im",
            int'(out_im), int'(pat_im(sel, f, n)));
      end else begin
        chk(out_valid == 1'b0, (c < 0) ? "R2" : {"R4", extra}, "early valid",
            int'(out_valid), 0);
      end
      if (c < 0) begin
        start = 1'b0;
        in_re = 12'hBAD ^ W'(c);
        in_im = 12'h5A5;
      end else begin
        start = (c == 0) || (c == pulse_at);
        in_re = pat_re(sel, c / N, c % N);
        in_im = pat_im(sel, c / N, c % N);
      end
    end
    start = 1'b0;
  endtask

  task automatic t_ramp();
    do_reset("R1");
    stream(0, 3, 0, -1, "");
  endtask

  task automatic t_extremes();
    do_reset("R1");
    stream(1, 2, 0, -1, "");
  endtask

  task automatic t_junk_first();
    do_reset("R1");
    stream(2, 2, 5, -1, "");
  endtask

  task automatic t_restart_pulse();
    do_reset("R1");
    stream(0, 3, 2, N + 3, " R8");
  endtask

  task automatic t_mid_reset();
    do_reset("R1");
    stream(2, 1, 0, -1, "");
    do_reset("R9");
    stream(1, 2, 3, -1, " R9");
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_ramp();
    t_extremes();
    t_junk_first();
    t_restart_pulse();
    t_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule